// File: doc/BRIEF.md
# Active Priority Tracker with End-of-Interrupt Handling

This block records which priority levels are in service for three interrupt groups: group 0, secure group 1 and non-secure group 1. Each group owns a bitmap of active levels. When the CPU side acknowledges the winning pending interrupt, the block marks that interrupt's masked priority level as active in the interrupt's group. It also emits a one-cycle pulse that tells the surrounding logic to move the interrupt from pending to active.

When software writes an end-of-interrupt, the block finds the group that holds the most urgent active level. If that group is the one the write targets, it drops that level. Depending on the end-of-interrupt mode selected for the current CPU state, it may also request deactivation of the interrupt. The running priority, meaning the most urgent level still in service, is always presented on an output.

Pending-interrupt selection, the distributor and the register-bus decode sit outside this block. They talk to it through single-cycle request strobes.

Top module: `active_prio_tracker`

## Requirements
- R1: After reset all three bitmaps are empty, `running_prio` is 0xFF, `top_grp` is 3 (none) and `act_valid`, `drop_valid` and `deact_valid` are low.
- R2: An acknowledge sets level index (`ack_prio` & `ack_mask`) >> 1 in the bitmap of `ack_grp`, where group code 0 is group 0, 1 is secure group 1 and 2 is non-secure group 1. An index of LEVELS (32) or more sets nothing, and group code 3 sets nothing. The new state is visible the cycle after the strobe.
- R3: Every acknowledge strobe produces, one cycle later, a one-cycle `act_valid` pulse with `act_id` equal to the acknowledged `ack_id`.
- R4: `running_prio` is twice the lowest set level index across all three bitmaps, or 0xFF when all are empty.
- R5: `top_grp` names the group holding the lowest set index. Ties are resolved in this order: group 0, then secure group 1, then non-secure group 1. The value is 3 when nothing is active.
- R6: An end-of-interrupt whose 24-bit ID is NUM_IRQ (1020) or above has no effect on any bitmap or output.
- R7: The target group of an end-of-interrupt is group 0 when `eoi_grp1` is 0. When `eoi_grp1` is 1, the target is secure group 1 if `cpu_secure` is 1 and non-secure group 1 otherwise. A write whose target differs from `top_grp` has no effect.
- R8: An accepted end-of-interrupt clears the lowest set bit of the target group's bitmap and gives a one-cycle `drop_valid` pulse the next cycle.
- R9: The mode bit is `split_mon` when `cpu_monitor` is 1. Otherwise it is `split_el1_s` when `cpu_secure` is 1, and `split_el1_ns` in all other cases. When an accepted end-of-interrupt finds the mode bit clear, `deact_valid` pulses together with `drop_valid` and `deact_id` carries the written ID. When the bit is set, only the drop happens.
- R10: When an acknowledge and an end-of-interrupt arrive in the same cycle, the end-of-interrupt is judged and applied on the bitmaps as they stood before that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_req | input | 1 | Acknowledge strobe |
| ack_grp | input | 2 | Group of the acknowledged interrupt (0, 1, 2; 3 = none) |
| ack_prio | input | PRIO_W | Priority of the acknowledged interrupt |
| ack_mask | input | PRIO_W | Priority mask for that group |
| ack_id | input | ID_W | ID of the acknowledged interrupt |
| eoi_req | input | 1 | End-of-interrupt strobe |
| eoi_grp1 | input | 1 | 0 = group 0 register, 1 = group 1 register |
| eoi_id | input | ID_W | ID written with the end-of-interrupt |
| cpu_secure | input | 1 | CPU is in secure state |
| cpu_monitor | input | 1 | CPU runs at monitor level |
| split_mon | input | 1 | Split-mode bit used at monitor level |
| split_el1_s | input | 1 | Split-mode bit for secure state |
| split_el1_ns | input | 1 | Split-mode bit for non-secure state |
| act_valid | output | 1 | Pending-to-active request pulse |
| act_id | output | ID_W | ID to activate |
| drop_valid | output | 1 | Priority drop happened |
| deact_valid | output | 1 | Deactivation request pulse |
| deact_id | output | ID_W | ID to deactivate |
| running_prio | output | PRIO_W | Current running priority |
| top_grp | output | 2 | Group with the most urgent active level |

## Verification
On every cycle, the assertions check how the outputs relate to one another and to the strobes one cycle earlier:
- the acknowledge pulse and its ID (R3);
- that a drop or a deactivation only follows an accepted end-of-interrupt (R8, R9);
- that spurious IDs are ignored (R6);
- that `running_prio` agrees with the empty-state group code (R4, R5);
- that a fresh acknowledge bounds the running priority (R2).

Tie-breaking between groups, the mapping of target group and mode bit from CPU state, and the same-cycle ordering of acknowledge and end-of-interrupt depend on the accumulated bitmap history. Only the bench's scenarios and its cycle-by-cycle reference model can show those.

// File: rtl/apt_pkg.sv
package apt_pkg;
   typedef enum logic [1:0] {
      GRP_G0   = 2'd0,
      GRP_G1S  = 2'd1,
      GRP_G1NS = 2'd2,
      GRP_NONE = 2'd3
   } apt_grp_e;

   localparam int unsigned NUM_GROUPS = 3;
endpackage

// File: rtl/apt_lowbit.sv
// Finds the lowest set bit of a vector.
module apt_lowbit #(
   parameter int unsigned W  = 32,
   localparam int unsigned IW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/apt_group_bank.sv
// One group's active-level bitmap: set on acknowledge, lowest bit cleared on drop.
module apt_group_bank #(
   parameter int unsigned LEVELS = 32,
   localparam int unsigned IW    = $clog2(LEVELS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [IW-1:0]     set_idx,
   input  logic              drop_en,
   output logic [LEVELS-1:0] bitmap
);
   logic [LEVELS-1:0] set_vec;
   logic [LEVELS-1:0] kept;

   always_comb begin
      set_vec = '0;
      if (set_en) set_vec[set_idx] = 1'b1;
      // clearing the lowest set bit of the whole map equals clearing it in the first nonzero word
      kept = drop_en ? (bitmap & (bitmap - LEVELS'(1))) : bitmap;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bitmap <= '0;
      else        bitmap <= kept | set_vec;
   end
endmodule

// File: rtl/apt_select.sv
// Picks the group holding the most urgent active level, with fixed tie order.
module apt_select
   import apt_pkg::*;
#(
   parameter int unsigned LEVELS = 32,
   localparam int unsigned IW    = $clog2(LEVELS)
) (
   input  logic [NUM_GROUPS-1:0][LEVELS-1:0] maps,
   output apt_grp_e                          grp,
   output logic                              any,
   output logic [IW-1:0]                     best_idx
);
   logic [NUM_GROUPS-1:0]         g_any;
   logic [NUM_GROUPS-1:0][IW-1:0] g_idx;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_low
      apt_lowbit #(.W(LEVELS)) u_low (
         .vec (maps[g]),
         .any (g_any[g]),
         .idx (g_idx[g])
      );
   end

   logic ns_wins, s_wins;
   always_comb begin
      ns_wins = g_any[GRP_G1NS]
              && (!g_any[GRP_G0]  || (g_idx[GRP_G1NS] < g_idx[GRP_G0]))
              && (!g_any[GRP_G1S] || (g_idx[GRP_G1NS] < g_idx[GRP_G1S]));
      s_wins  = g_any[GRP_G1S]
              && (!g_any[GRP_G0]  || (g_idx[GRP_G1S] < g_idx[GRP_G0]));
      if (ns_wins) begin
         grp = GRP_G1NS; best_idx = g_idx[GRP_G1NS];
      end else if (s_wins) begin
         grp = GRP_G1S;  best_idx = g_idx[GRP_G1S];
      end else if (g_any[GRP_G0]) begin
         grp = GRP_G0;   best_idx = g_idx[GRP_G0];
      end else begin
         grp = GRP_NONE; best_idx = '0;
      end
      any = |g_any;
   end
endmodule

// File: rtl/apt_eoi_ctrl.sv
// Decides whether an end-of-interrupt is accepted, which group it drops, and whether it deactivates.
module apt_eoi_ctrl
   import apt_pkg::*;
#(
   parameter int unsigned ID_W    = 24,
   parameter int unsigned NUM_IRQ = 1020
) (
   input  logic            eoi_req,
   input  logic            eoi_grp1,
   input  logic [ID_W-1:0] eoi_id,
   input  logic            cpu_secure,
   input  logic            cpu_monitor,
   input  logic            split_mon,
   input  logic            split_el1_s,
   input  logic            split_el1_ns,
   input  apt_grp_e        cur_grp,
   output logic            accept,
   output apt_grp_e        target,
   output logic            deact
);
   logic id_ok, split;

   always_comb begin
      id_ok  = (32'(eoi_id) < NUM_IRQ);
      if (!eoi_grp1)       target = GRP_G0;
      else if (cpu_secure) target = GRP_G1S;
      else                 target = GRP_G1NS;
      if (cpu_monitor)     split = split_mon;
      else if (cpu_secure) split = split_el1_s;
      else                 split = split_el1_ns;
      accept = eoi_req && id_ok && (cur_grp == target);
      deact  = accept && !split;
   end
endmodule

// File: rtl/active_prio_tracker.sv
module active_prio_tracker
   import apt_pkg::*;
#(
   parameter int unsigned LEVELS  = 32,
   parameter int unsigned PRIO_W  = 8,
   parameter int unsigned ID_W    = 24,
   parameter int unsigned NUM_IRQ = 1020
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ack_req,
   input  logic [1:0]        ack_grp,
   input  logic [PRIO_W-1:0] ack_prio,
   input  logic [PRIO_W-1:0] ack_mask,
   input  logic [ID_W-1:0]   ack_id,
   input  logic              eoi_req,
   input  logic              eoi_grp1,
   input  logic [ID_W-1:0]   eoi_id,
   input  logic              cpu_secure,
   input  logic              cpu_monitor,
   input  logic              split_mon,
   input  logic              split_el1_s,
   input  logic              split_el1_ns,
   output logic              act_valid,
   output logic [ID_W-1:0]   act_id,
   output logic              drop_valid,
   output logic              deact_valid,
   output logic [ID_W-1:0]   deact_id,
   output logic [PRIO_W-1:0] running_prio,
   output logic [1:0]        top_grp
);
   localparam int unsigned IW = $clog2(LEVELS);

   if (LEVELS < 2 || (LEVELS * 2) > (1 << PRIO_W)) begin : g_bad_levels
      $error("LEVELS must be at least 2 and fit the priority width");
   end
   if (ID_W < 11 || ID_W > 32) begin : g_bad_idw
      $error("ID_W must hold the spurious ID range and be at most 32");
   end

   logic [NUM_GROUPS-1:0][LEVELS-1:0] maps;
   logic [NUM_GROUPS-1:0]             set_en, drop_en;
   logic [PRIO_W-1:0]                 masked;
   logic [PRIO_W-2:0]                 lvl;
   logic                              lvl_ok;
   apt_grp_e                          cur_grp, target;
   logic                              any_act, accept, deact;
   logic [IW-1:0]                     best_idx;

   always_comb begin
      masked = ack_prio & ack_mask;
      lvl    = masked[PRIO_W-1:1];
      lvl_ok = (32'(lvl) < LEVELS);
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
      assign set_en[g]  = ack_req && lvl_ok && (ack_grp == 2'(g));
      assign drop_en[g] = accept && (target == apt_grp_e'(g));
      apt_group_bank #(.LEVELS(LEVELS)) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .set_en  (set_en[g]),
         .set_idx (IW'(lvl)),
         .drop_en (drop_en[g]),
         .bitmap  (maps[g])
      );
   end

   apt_select #(.LEVELS(LEVELS)) u_sel (
      .maps     (maps),
      .grp      (cur_grp),
      .any      (any_act),
      .best_idx (best_idx)
   );

   apt_eoi_ctrl #(.ID_W(ID_W), .NUM_IRQ(NUM_IRQ)) u_eoi (
      .eoi_req      (eoi_req),
      .eoi_grp1     (eoi_grp1),
      .eoi_id       (eoi_id),
      .cpu_secure   (cpu_secure),
      .cpu_monitor  (cpu_monitor),
      .split_mon    (split_mon),
      .split_el1_s  (split_el1_s),
      .split_el1_ns (split_el1_ns),
      .cur_grp      (cur_grp),
      .accept       (accept),
      .target       (target),
      .deact        (deact)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_valid   <= 1'b0;
         act_id      <= '0;
         drop_valid  <= 1'b0;
         deact_valid <= 1'b0;
         deact_id    <= '0;
      end else begin
         act_valid   <= ack_req;
         drop_valid  <= accept;
         deact_valid <= deact;
         if (ack_req) act_id   <= ack_id;
         if (deact)   deact_id <= eoi_id;
      end
   end

   always_comb begin
      running_prio = any_act ? PRIO_W'({best_idx, 1'b0}) : '1;
      top_grp      = cur_grp;
   end
endmodule

// File: rtl/apt_checker.sv
module apt_checker #(
   parameter int unsigned LEVELS  = 32,
   parameter int unsigned PRIO_W  = 8,
   parameter int unsigned ID_W    = 24,
   parameter int unsigned NUM_IRQ = 1020
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack_req,
   input logic [1:0]        ack_grp,
   input logic [PRIO_W-1:0] ack_prio,
   input logic [PRIO_W-1:0] ack_mask,
   input logic [ID_W-1:0]   ack_id,
   input logic              eoi_req,
   input logic [ID_W-1:0]   eoi_id,
   input logic              act_valid,
   input logic [ID_W-1:0]   act_id,
   input logic              drop_valid,
   input logic              deact_valid,
   input logic [ID_W-1:0]   deact_id,
   input logic [PRIO_W-1:0] running_prio,
   input logic [1:0]        top_grp
);
   logic [PRIO_W-1:0] mp;
   logic              lvl_in;
   assign mp     = ack_prio & ack_mask;
   assign lvl_in = (32'(mp[PRIO_W-1:1]) < LEVELS);

   assert_ack_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req |=> act_valid && (act_id == $past(ack_id)));
   assert_no_ack_no_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_req |=> !act_valid);
   assert_ack_bounds_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && !eoi_req && ack_grp != 2'd3 && lvl_in)
         |=> running_prio <= $past({mp[PRIO_W-1:1], 1'b0}));
   assert_drop_needs_eoi_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !eoi_req |=> !drop_valid);
   assert_spurious_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_req && 32'(eoi_id) >= NUM_IRQ) |=> !drop_valid && !deact_valid);
   assert_deact_with_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      deact_valid |-> drop_valid && (deact_id == $past(eoi_id)));
   assert_idle_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (top_grp == 2'd3) == (running_prio == {PRIO_W{1'b1}}));
endmodule

bind active_prio_tracker apt_checker #(
   .LEVELS(LEVELS), .PRIO_W(PRIO_W), .ID_W(ID_W), .NUM_IRQ(NUM_IRQ)
) u_apt_chk (
   .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .ack_grp(ack_grp),
   .ack_prio(ack_prio), .ack_mask(ack_mask), .ack_id(ack_id),
   .eoi_req(eoi_req), .eoi_id(eoi_id), .act_valid(act_valid),
   .act_id(act_id), .drop_valid(drop_valid), .deact_valid(deact_valid),
   .deact_id(deact_id), .running_prio(running_prio), .top_grp(top_grp)
);

// File: tb/active_prio_tracker_bench.sv
`timescale 1ns/1ps
module active_prio_tracker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ack_req = 0, eoi_req = 0, eoi_grp1 = 0;
   logic [1:0]  ack_grp = 0;
   logic [7:0]  ack_prio = 0, ack_mask = 8'hFF;
   logic [23:0] ack_id = 0, eoi_id = 0;
   logic        cpu_secure = 0, cpu_monitor = 0;
   logic        split_mon = 0, split_el1_s = 0, split_el1_ns = 0;
   logic        act_valid, drop_valid, deact_valid;
   logic [23:0] act_id, deact_id;
   logic [7:0]  running_prio;
   logic [1:0]  top_grp;

   always #5 clk = ~clk;

   active_prio_tracker u_active_prio_tracker (
      .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .ack_grp(ack_grp),
      .ack_prio(ack_prio), .ack_mask(ack_mask), .ack_id(ack_id),
      .eoi_req(eoi_req), .eoi_grp1(eoi_grp1), .eoi_id(eoi_id),
      .cpu_secure(cpu_secure), .cpu_monitor(cpu_monitor),
      .split_mon(split_mon), .split_el1_s(split_el1_s), .split_el1_ns(split_el1_ns),
      .act_valid(act_valid), .act_id(act_id), .drop_valid(drop_valid),
      .deact_valid(deact_valid), .deact_id(deact_id),
      .running_prio(running_prio), .top_grp(top_grp)
   );

   int tests = 0, fails = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // ---- behavioural reference model ----
   logic [31:0] m_map [3];
   bit          m_act, m_drop, m_deact;
   int          m_act_id, m_deact_id;

   function automatic int lowest(input logic [31:0] v);
      for (int i = 0; i < 32; i++) if (v[i]) return i;
      return 32;
   endfunction

   function automatic int pick_grp();
      int l0 = lowest(m_map[0]), l1 = lowest(m_map[1]), l2 = lowest(m_map[2]);
      int best = 32, g = 3;
      // tie order group 0, secure group 1, non-secure group 1
      if (l0 < best) begin best = l0; g = 0; end
      if (l1 < best) begin best = l1; g = 1; end
      if (l2 < best) begin best = l2; g = 2; end
      return g;
   endfunction

   function automatic int model_prio();
      int b = lowest(m_map[0]);
      if (lowest(m_map[1]) < b) b = lowest(m_map[1]);
      if (lowest(m_map[2]) < b) b = lowest(m_map[2]);
      return (b == 32) ? 255 : b * 2;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int g = 0; g < 3; g++) m_map[g] = '0;
         m_act = 0; m_drop = 0; m_deact = 0; m_act_id = 0; m_deact_id = 0;
      end else begin
         int tgt, cur, lvl;
         bit split;
         cur = pick_grp();
         tgt = !eoi_grp1 ? 0 : (cpu_secure ? 1 : 2);
         split = cpu_monitor ? split_mon : (cpu_secure ? split_el1_s : split_el1_ns);
         m_drop = eoi_req && (int'(eoi_id) < 1020) && (cur == tgt);
         m_deact = m_drop && !split;
         if (m_deact) m_deact_id = int'(eoi_id);
         if (m_drop) m_map[tgt] = m_map[tgt] & (m_map[tgt] - 1);
         m_act = ack_req;
         if (ack_req) m_act_id = int'(ack_id);
         lvl = int'(ack_prio & ack_mask) >> 1;
         if (ack_req && ack_grp != 2'd3 && lvl < 32) m_map[ack_grp][lvl] = 1'b1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(running_prio == 8'(model_prio()), "R4 running_prio", running_prio, model_prio());
         chk(top_grp == 2'(pick_grp()), "R5 top_grp", top_grp, pick_grp());
         chk(act_valid == m_act, "R3 act_valid", act_valid, m_act);
         if (m_act) chk(act_id == 24'(m_act_id), "R3 act_id", act_id, m_act_id);
         chk(drop_valid == m_drop, "R8 drop_valid", drop_valid, m_drop);
         chk(deact_valid == m_deact, "R9 deact_valid", deact_valid, m_deact);
         if (m_deact) chk(deact_id == 24'(m_deact_id), "R9 deact_id", deact_id, m_deact_id);
      end
   end

   // ---- stimulus helpers (drive at negedge, result visible next negedge) ----
   task automatic do_ack(input int g, input int p, input int m, input int id);
      ack_req = 1; ack_grp = 2'(g); ack_prio = 8'(p); ack_mask = 8'(m); ack_id = 24'(id);
      @(negedge clk);
      ack_req = 0;
   endtask

   task automatic do_eoi(input bit g1, input int id);
      eoi_req = 1; eoi_grp1 = g1; eoi_id = 24'(id);
      @(negedge clk);
      eoi_req = 0;
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 50000) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(running_prio == 8'hFF, "R1 reset prio", running_prio, 8'hFF);
      chk(top_grp == 2'd3, "R1 reset grp", top_grp, 3);
      chk(!act_valid && !drop_valid && !deact_valid, "R1 reset pulses",
          {act_valid, drop_valid, deact_valid}, 0);

      // R2 out-of-range level sets nothing
      do_ack(0, 8'h40, 8'hFF, 77);
      chk(running_prio == 8'hFF, "R2 out of range", running_prio, 8'hFF);
      chk(act_valid && act_id == 77, "R3 pulse on ack", act_id, 77);
      do_ack(3, 8'h02, 8'hFF, 78);
      chk(running_prio == 8'hFF, "R2 group code 3", running_prio, 8'hFF);
      // R2 masking
      do_ack(2, 8'h13, 8'hF8, 40);
      chk(running_prio == 8'h10 && top_grp == 2, "R2 masked set", running_prio, 8'h10);
      do_ack(0, 8'h17, 8'hFE, 41);
      chk(running_prio == 8'h10, "R4 lower urgency kept", running_prio, 8'h10);
      do_ack(1, 8'h08, 8'hFF, 42);
      chk(top_grp == 1 && running_prio == 8'h08, "R5 secure g1 wins", top_grp, 1);

      // R7 target mismatch
      do_eoi(0, 41);
      chk(!drop_valid && running_prio == 8'h08, "R7 g0 reg ignored", drop_valid, 0);
      cpu_secure = 0;
      do_eoi(1, 42);
      chk(!drop_valid, "R7 ns target ignored", drop_valid, 0);
      // R8/R9 accepted in secure state, split set -> no deact
      cpu_secure = 1; split_el1_s = 1; split_el1_ns = 0;
      do_eoi(1, 42);
      chk(drop_valid && !deact_valid, "R9 split drop only", deact_valid, 0);
      chk(top_grp == 2 && running_prio == 8'h10, "R8 level cleared", running_prio, 8'h10);

      // R6 spurious ID
      cpu_secure = 0;
      do_eoi(1, 1020);
      chk(!drop_valid && running_prio == 8'h10, "R6 spurious ignored", drop_valid, 0);
      do_eoi(1, 1023);
      chk(!drop_valid, "R6 id 1023 ignored", drop_valid, 0);
      do_eoi(1, 1019);
      chk(drop_valid && deact_valid && deact_id == 1019, "R9 ns deact", deact_id, 1019);

      // R9 monitor-level bit
      cpu_monitor = 1; split_mon = 0; split_el1_ns = 1; split_el1_s = 1;
      do_eoi(0, 41);
      chk(deact_valid && deact_id == 41, "R9 monitor deact", deact_id, 41);
      chk(running_prio == 8'hFF && top_grp == 3, "R8 now empty", running_prio, 8'hFF);
      cpu_monitor = 0;

      // R5 ties
      do_ack(2, 6, 8'hFF, 10);
      do_ack(1, 6, 8'hFF, 11);
      do_ack(0, 6, 8'hFF, 12);
      chk(top_grp == 0, "R5 tie g0 first", top_grp, 0);
      do_eoi(0, 12);
      chk(top_grp == 1, "R5 tie g1s next", top_grp, 1);
      cpu_secure = 1;
      do_eoi(1, 11);
      chk(top_grp == 2 && running_prio == 8'h06, "R5 g1ns last", top_grp, 2);

      // R10 simultaneous ack and eoi: eoi judged before ack
      ack_req = 1; ack_grp = 0; ack_prio = 8'h02; ack_mask = 8'hFF; ack_id = 20;
      eoi_req = 1; eoi_grp1 = 0; eoi_id = 20;
      @(negedge clk);
      ack_req = 0; eoi_req = 0;
      chk(!drop_valid && top_grp == 0 && running_prio == 8'h02, "R10 eoi on old state",
          drop_valid, 0);
      cpu_secure = 0;
      ack_req = 1; ack_grp = 2; ack_prio = 8'h00; ack_id = 21;
      eoi_req = 1; eoi_grp1 = 0; eoi_id = 20;
      @(negedge clk);
      ack_req = 0; eoi_req = 0;
      chk(drop_valid && top_grp == 2 && running_prio == 8'h00, "R10 drop and set", running_prio, 0);

      repeat (2) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule